// File: doc/BRIEF.md
# Single-Step Shift Register with Overflow Flag

This block is a data register of parameterised width that, on each clock, either keeps its value, takes a new value from a parallel input, or moves its contents by exactly one bit position. A four-bit operation code picks the action. The shift family covers zero-fill shifts, rotations, sign-aware shifts, and two serial modes in which the incoming bit comes from a dedicated pin for each direction.

A separate overflow flag watches the sign-aware left shift. On the same edge that performs that shift, the flag takes the exclusive-OR of the two highest bits as they were before the shift. A set flag means the doubling reversed the sign. Every other operation leaves the flag alone.

A parallel load and a shift of the loaded value always take two separate edges, because one edge carries one operation. Reset is asynchronous and active low. Its release is synchronised to the clock through two flops.

Top module: `shreg_unit`

## Requirements
- R1: While reset is asserted, `reg_q` reads all zeros and `ovf_q` reads 0.
- R2: Operation code 1 (load) places `load_data` in `reg_q` on the next rising edge. A shift issued on the following cycle acts on that loaded value.
- R3: Operation code 0 (hold) and the unused codes 10 to 15 leave `reg_q` and `ovf_q` unchanged. `load_data` and both fill pins have no effect under these codes.
- R4: Code 3 shifts `reg_q` one place toward the MSB and puts 0 in bit 0. Code 2 shifts it one place toward the LSB and puts 0 in bit W-1. `load_data` is ignored during any shift.
- R5: Code 5 rotates toward the MSB, so the old bit W-1 enters bit 0. Code 4 rotates toward the LSB, so the old bit 0 enters bit W-1.
- R6: Code 6 (sign-keeping right shift) leaves bit W-1 at its old value and copies that value into bit W-2.
- R7: Code 7 (sign-aware left shift) moves every bit one place toward the MSB, puts 0 in bit 0 and drops the old bit W-1.
- R8: On code 7, `ovf_q` becomes old bit W-1 XOR old bit W-2, on the same edge that updates `reg_q`.
- R9: `ovf_q` holds its value under every code other than 7.
- R10: Code 9 shifts toward the MSB with `fill_left` entering bit 0. Code 8 shifts toward the LSB with `fill_right` entering bit W-1. For all shift codes 2 to 9, bit 0 of the code gives the direction: 1 means toward the MSB and 0 means toward the LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select (see R2 to R10) |
| load_data | input | W | Parallel load value |
| fill_left | input | 1 | Serial bit entering bit 0 under code 9 |
| fill_right | input | 1 | Serial bit entering bit W-1 under code 8 |
| reg_q | output | W | Register contents |
| ovf_q | output | 1 | Overflow flag from the last sign-aware left shift |

## Verification
Every register and flag result is due on the first rising edge after the code is applied. The overflow flag is due on that same edge, not one edge later. The bench changes inputs on falling edges and compares both outputs at the next falling edge, so each vector sees exactly one active edge. Reset is checked one nanosecond after `rst_n` falls, because clearing does not wait for a clock.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD = 4'd0,
    OP_LOAD = 4'd1,
    OP_LSR  = 4'd2,
    OP_LSL  = 4'd3,
    OP_ROR  = 4'd4,
    OP_ROL  = 4'd5,
    OP_ASR  = 4'd6,
    OP_ASL  = 4'd7,
    OP_SER  = 4'd8,
    OP_SEL  = 4'd9
  } op_e;
endpackage

// File: rtl/shreg_fill_sel.sv
module shreg_fill_sel
  import shreg_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  input  logic            msb_in,
  input  logic            lsb_in,
  input  logic            fill_left,
  input  logic            fill_right,
  output logic            is_shift,
  output logic            dir_left,
  output logic            fill_bit
);
  // bit 0 of every shift code selects the direction (1 = toward MSB)
  assign is_shift = (op_code >= OP_LSR) && (op_code <= OP_SEL);
  assign dir_left = op_code[0];

  always_comb begin
    fill_bit = 1'b0;
    case (op_code)
      OP_ROL:  fill_bit = msb_in;
      OP_ROR:  fill_bit = lsb_in;
      OP_ASR:  fill_bit = msb_in;
      OP_SEL:  fill_bit = fill_left;
      OP_SER:  fill_bit = fill_right;
      default: fill_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/shreg_shifter.sv
module shreg_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         dir_left,
  input  logic         fill_bit,
  output logic [W-1:0] dout
);
  logic [W-1:0] up_v;
  logic [W-1:0] dn_v;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign up_v[i] = fill_bit;
    end else begin : g_lo_mid
      assign up_v[i] = din[i-1];
    end
    if (i == W-1) begin : g_hi
      assign dn_v[i] = fill_bit;
    end else begin : g_hi_mid
      assign dn_v[i] = din[i+1];
    end
  end

  assign dout = dir_left ? up_v : dn_v;
endmodule

// File: rtl/shreg_ovf.sv
module shreg_ovf
  import shreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_q,
  input  logic [OP_W-1:0] op_code,
  input  logic            top_bit,
  input  logic            next_bit,
  output logic            ovf_q
);
  logic ovf_en;
  logic ovf_d;

  always_comb begin
    ovf_en = (op_code == OP_ASL);
    ovf_d  = top_bit ^ next_bit;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  assert_ovf_capture_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_ASL) |=> (ovf_q == ($past(top_bit) ^ $past(next_bit))));

  assert_ovf_keep_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code != OP_ASL) |=> $stable(ovf_q));
endmodule

// File: rtl/shreg_unit.sv
module shreg_unit
  import shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    load_data,
  input  logic            fill_left,
  input  logic            fill_right,
  output logic [W-1:0]    reg_q,
  output logic            ovf_q
);
  localparam int MSB = W - 1;

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic         is_shift;
  logic         dir_left;
  logic         fill_bit;
  logic [W-1:0] shifted;
  logic [W-1:0] q_d;
  logic         q_en;

  shreg_fill_sel u_fill (
    .op_code    (op_code),
    .msb_in     (reg_q[MSB]),
    .lsb_in     (reg_q[0]),
    .fill_left  (fill_left),
    .fill_right (fill_right),
    .is_shift   (is_shift),
    .dir_left   (dir_left),
    .fill_bit   (fill_bit)
  );

  shreg_shifter #(.W(W)) u_shift (
    .din      (reg_q),
    .dir_left (dir_left),
    .fill_bit (fill_bit),
    .dout     (shifted)
  );

  shreg_ovf u_ovf (
    .clk      (clk),
    .rst_q    (rst_q),
    .op_code  (op_code),
    .top_bit  (reg_q[MSB]),
    .next_bit (reg_q[MSB-1]),
    .ovf_q    (ovf_q)
  );

  always_comb begin
    q_d  = reg_q;
    q_en = 1'b0;
    if (op_code == OP_LOAD) begin
      q_en = 1'b1;
      q_d  = load_data;
    end else if (is_shift) begin
      q_en = 1'b1;
      q_d  = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)    reg_q <= '0;
    else if (q_en) reg_q <= q_d;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_q |-> (reg_q == '0 && ovf_q == 1'b0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_LOAD) |=> (reg_q == $past(load_data)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_HOLD || op_code > OP_SEL) |=> ($stable(reg_q) && $stable(ovf_q)));

  assert_lsl_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_LSL) |=> (reg_q == {$past(reg_q[MSB-1:0]), 1'b0}));

  assert_rol_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_ROL) |=> (reg_q == {$past(reg_q[MSB-1:0]), $past(reg_q[MSB])}));

  assert_asr_sign_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_ASR) |=> (reg_q[MSB] == $past(reg_q[MSB]) && reg_q[MSB-1] == $past(reg_q[MSB])));

  assert_asl_zero_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_ASL) |=> (reg_q[0] == 1'b0));

  assert_serial_left_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (op_code == OP_SEL) |=> (reg_q[0] == $past(fill_left)));
endmodule

// File: tb/test_shreg_unit.sv
`timescale 1ns/1ps
module test_shreg_unit;
  localparam int W = 8;
  localparam int NV = 26;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   op_code;
  logic [W-1:0] load_data;
  logic         fill_left;
  logic         fill_right;
  logic [W-1:0] reg_q;
  logic         ovf_q;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  shreg_unit #(.W(W)) i_shreg_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .load_data  (load_data),
    .fill_left  (fill_left),
    .fill_right (fill_right),
    .reg_q      (reg_q),
    .ovf_q      (ovf_q)
  );

  // entry: {op, load_data, fill_left, fill_right, expected reg_q, expected ovf_q}
  localparam logic [22:0] VEC [NV] = '{
    {4'd1, 8'hB4, 1'b0, 1'b0, 8'hB4, 1'b0}, // R2 load
    {4'd3, 8'h00, 1'b0, 1'b0, 8'h68, 1'b0}, // R4 zero-fill left
    {4'd2, 8'h00, 1'b0, 1'b0, 8'h34, 1'b0}, // R4 zero-fill right
    {4'd1, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0}, // R2 load
    {4'd5, 8'h00, 1'b0, 1'b0, 8'h03, 1'b0}, // R5 rotate left
    {4'd4, 8'h00, 1'b0, 1'b0, 8'h81, 1'b0}, // R5 rotate right
    {4'd4, 8'h00, 1'b0, 1'b0, 8'hC0, 1'b0}, // R5 rotate right
    {4'd6, 8'h00, 1'b0, 1'b0, 8'hE0, 1'b0}, // R6 sign kept
    {4'd7, 8'h00, 1'b0, 1'b0, 8'hC0, 1'b0}, // R7 R8 no reversal
    {4'd7, 8'h00, 1'b0, 1'b0, 8'h80, 1'b0}, // R7 R8 no reversal
    {4'd7, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R8 reversal 1->0
    {4'd0, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b1}, // R3 R9 hold
    {4'd1, 8'h40, 1'b0, 1'b0, 8'h40, 1'b1}, // R9 load keeps flag
    {4'd7, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1}, // R8 reversal 0->1
    {4'd2, 8'h00, 1'b0, 1'b0, 8'h40, 1'b1}, // R9 shift keeps flag
    {4'd1, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b1}, // R2 load
    {4'd7, 8'h00, 1'b0, 1'b0, 8'h78, 1'b0}, // R8 flag clears
    {4'd6, 8'h00, 1'b0, 1'b0, 8'h3C, 1'b0}, // R6 positive value
    {4'd9, 8'h00, 1'b1, 1'b0, 8'h79, 1'b0}, // R10 serial left, 1 in
    {4'd8, 8'h00, 1'b0, 1'b1, 8'hBC, 1'b0}, // R10 serial right, 1 in
    {4'd8, 8'h00, 1'b1, 1'b0, 8'h5E, 1'b0}, // R10 serial right, 0 in
    {4'd9, 8'h00, 1'b0, 1'b1, 8'hBC, 1'b0}, // R10 serial left, 0 in
    {4'd12, 8'hFF, 1'b1, 1'b1, 8'hBC, 1'b0}, // R3 unused code
    {4'd15, 8'h00, 1'b1, 1'b1, 8'hBC, 1'b0}, // R3 unused code
    {4'd0, 8'h55, 1'b1, 1'b1, 8'hBC, 1'b0}, // R3 hold ignores inputs
    {4'd3, 8'hFF, 1'b1, 1'b1, 8'h78, 1'b0}  // R4 shift ignores load_data
  };

  task automatic check(input string tag, input logic [W-1:0] aq, input logic [W-1:0] eq,
                       input logic ao, input logic eo);
    checks++;
    if (aq !== eq || ao !== eo) begin
      failures++;
      $display("FAIL %s reg_q=%h expected %h ovf_q=%b expected %b", tag, aq, eq, ao, eo);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [W-1:0] d, input logic fl, input logic fr);
    op_code = op; load_data = d; fill_left = fl; fill_right = fr;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired reg_q=%h expected completion", reg_q);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_code = 4'd0; load_data = '0; fill_left = 1'b0; fill_right = 1'b0;
    #1;
    check("R1 reset at start", reg_q, 8'h00, ovf_q, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset held", reg_q, 8'h00, ovf_q, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", reg_q, 8'h00, ovf_q, 1'b0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][22:19], VEC[k][18:11], VEC[k][10], VEC[k][9]);
      check($sformatf("vector %0d", k), reg_q, VEC[k][8:1], ovf_q, VEC[k][0]);
    end

    // R2: load then shift on the next cycle works on the loaded value
    step(4'd1, 8'h01, 1'b0, 1'b0);
    step(4'd2, 8'h00, 1'b0, 1'b0);
    check("R2 load then shift", reg_q, 8'h00, ovf_q, 1'b0);

    // R8: flag set, then asynchronous reset clears both (R1)
    step(4'd1, 8'h7F, 1'b0, 1'b0);
    step(4'd7, 8'h00, 1'b0, 1'b0);
    check("R8 0111_1111 reverses", reg_q, 8'hFE, ovf_q, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", reg_q, 8'h00, ovf_q, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after second release", reg_q, 8'h00, ovf_q, 1'b0);

    // R6: all-ones stays all-ones under sign-keeping right shift
    step(4'd1, 8'hFF, 1'b0, 1'b0);
    step(4'd6, 8'h00, 1'b0, 1'b0);
    check("R6 all ones", reg_q, 8'hFF, ovf_q, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule